// File: doc/BRIEF.md
# Bus-mapped reloading down-counter timer

This block is a 32-bit down-counting timer behind an APB slave port. Software writes a start value and a reload value, sets the enable bit, and the counter steps down by one on each counting tick. When the count steps from 1 to 0, an interrupt is raised if the interrupt enable bit is set. The count then rests at zero for one tick and reloads. A reload value of zero parks the counter at zero. A single level interrupt line follows a sticky status bit, which software clears by writing a one.

An external input can gate the ticks in two ways. It can act as a count enable, so the counter steps only while the input is high. It can also act as a slow count clock, so the counter steps once per rising edge. In both cases the input first passes through a two-flop synchronizer. Read-only identification bytes sit near the top of the 4 KB register window.

Top module: `apb_dtimer`

## Requirements
- R1: After reset, the control, value, reload and status registers read zero, and `irq` is low.
- R2: Control (offset 0x000) stores only bits [3:0]: bit 0 is the enable, bit 1 selects external count enable, bit 2 selects external count clock, and bit 3 is the interrupt enable. Bits above bit 3 read as zero.
- R3: With bit 0 set and neither external mode selected, the count (offset 0x004) drops by one on every clock. With bit 0 clear, the count holds its value.
- R4: The status bit (offset 0x00C, bit 0) is set on a 1-to-0 step of the count, and only when the interrupt enable is set at that step.
- R5: After reaching 0, the count stays at 0 for exactly one tick and then takes the reload value. With a reload value of 0, the count stays at 0 and the status bit never sets.
- R6: A write to reload (offset 0x008) sets both the reload value and the count to the written data.
- R7: A write to the value register sets the count and leaves the reload value unchanged.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. `irq` always equals the status bit.
- R9: In external-enable mode, one tick occurs on each clock while the synchronized `ext_in` is high. A one-cycle high pulse on `ext_in` causes exactly one decrement, on the third rising clock edge after the pulse is applied.
- R10: In external-clock mode, one tick occurs per rising edge of the synchronized `ext_in`, however long the input stays high. If both mode bits are set, both conditions must hold.
- R11: Offsets 0xFD0 to 0xFFC, one word each, read the bytes 04,00,00,00,22,B8,1B,00,0D,F0,05,B1 in ascending address order. Writes to these offsets are ignored.
- R12: Unmapped offsets read as zero and ignore writes. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| ext_in | input | 1 | External enable or slow clock |
| irq | output | 1 | Level interrupt |

## Verification
The count is tried with free-running clock ticks. This separates the exact cycle of the 1-to-0 interrupt from off-by-one errors in the decrement and the reload. Single external pulses step the counter one tick at a time, which exposes the one-tick hold at zero and the two-flop synchronizer latency. A long high level in clock mode separates edge detection from level gating. Zero-reload and interrupt-disabled runs confirm that the status bit stays clear. Register writes are applied to the reload, value, status, identification and unmapped offsets, and each result is read back at the ports.

// File: rtl/apb_dtimer.sv
module apb_dtimer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [11:0]   paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          ext_in,
  output logic          irq
);
  logic [3:0]    ctrl;
  logic [DW-1:0] cnt, rld;
  logic          ists;
  logic [2:0]    xs;

  wire wr     = psel & penable & pwrite;
  wire at_ctl = paddr[11:2] == 10'h000;
  wire at_val = paddr[11:2] == 10'h001;
  wire at_rld = paddr[11:2] == 10'h002;
  wire at_sts = paddr[11:2] == 10'h003;
  wire at_id  = paddr[11:6] == 6'h3F && paddr[5:4] != 2'b00;

  wire ld_any = wr & (at_rld | at_val);
  wire step   = ctrl[0] & (~ctrl[1] | xs[1]) & (~ctrl[2] | (xs[1] & ~xs[2]));
  wire hit    = step & ~ld_any & (cnt == DW'(1)) & ctrl[3];

  logic [7:0] id_byte;
  always_comb begin
    case (paddr[5:2])
      4'd4:    id_byte = 8'h04;
      4'd8:    id_byte = 8'h22;
      4'd9:    id_byte = 8'hB8;
      4'd10:   id_byte = 8'h1B;
      4'd12:   id_byte = 8'h0D;
      4'd13:   id_byte = 8'hF0;
      4'd14:   id_byte = 8'h05;
      4'd15:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    prdata = '0;
    if (at_ctl)      prdata = DW'(ctrl);
    else if (at_val) prdata = cnt;
    else if (at_rld) prdata = rld;
    else if (at_sts) prdata = DW'(ists);
    else if (at_id)  prdata = DW'(id_byte);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cnt  <= '0;
      rld  <= '0;
      ists <= 1'b0;
      xs   <= '0;
    end else begin
      xs <= {xs[1:0], ext_in};
      if (wr && at_ctl) ctrl <= pwdata[3:0];
      if (wr && at_rld) begin
        rld <= pwdata;
        cnt <= pwdata;
      end else if (wr && at_val) begin
        cnt <= pwdata;
      end else if (step) begin
        cnt <= (cnt == '0) ? rld : cnt - DW'(1);
      end
      if (hit)                            ists <= 1'b1;
      else if (wr && at_sts && pwdata[0]) ists <= 1'b0;
    end
  end

  assign irq     = ists;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

module apb_dtimer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [11:0]   paddr,
  input logic [DW-1:0] pwdata,
  input logic [3:0]    ctrl,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] rld,
  input logic          irq
);
  // R4
  a_r4_irq_from_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt) == DW'(1) && $past(ctrl[3])));
  // R5
  a_r5_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 4'b0001 && cnt == '0 && !wr) |=> cnt == $past(rld));
  // R6
  a_r6_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'h008) |=> (cnt == $past(pwdata) && rld == $past(pwdata)));
  // R7
  a_r7_value_keeps_rld: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'h004) |=> (cnt == $past(pwdata) && $stable(rld)));
  // R3
  a_r3_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr) |=> $stable(cnt));
  // R8
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'h00C && pwdata[0] && cnt != DW'(1)) |=> !irq);
endmodule

bind apb_dtimer apb_dtimer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .paddr(paddr), .pwdata(pwdata),
  .ctrl(ctrl), .cnt(cnt), .rld(rld), .irq(irq)
);

// File: tb/apb_dtimer_tb.sv
module apb_dtimer_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, ext_in = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, irq;

  int checks = 0, errors = 0;
  string       tag_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  apb_dtimer u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    wait (act_q.size() > 0);
    chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    tag_q.push_back(tag); exp_q.push_back(exp);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    act_q.push_back(prdata);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic pulse();
    @(negedge clk); ext_in = 1;
    @(negedge clk); ext_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    rd(12'h000, 0, "R1 ctrl");
    rd(12'h004, 0, "R1 value");
    rd(12'h008, 0, "R1 reload");
    rd(12'h00C, 0, "R1 status");
    chk("R12 pready", pready, 1);
    chk("R12 pslverr", pslverr, 0);

    begin
      logic [7:0] ids [12] = '{8'h04,8'h00,8'h00,8'h00,8'h22,8'hB8,8'h1B,8'h00,8'h0D,8'hF0,8'h05,8'hB1};
      for (int i = 0; i < 12; i++) rd(12'hFD0 + 12'(4*i), 32'(ids[i]), "R11 id");
    end
    wr(12'hFD0, 32'hFF);
    rd(12'hFD0, 32'h04, "R11 id write ignored");
    wr(12'h010, 32'h1234);
    rd(12'h010, 0, "R12 unmapped");
    rd(12'h004, 0, "R12 unmapped write no effect");

    wr(12'h000, 32'hFFFF_FFF6);
    rd(12'h000, 32'h6, "R2 ctrl bits");
    wr(12'h000, 0);

    wr(12'h008, 32'h20);
    rd(12'h004, 32'h20, "R6 count loaded");
    rd(12'h008, 32'h20, "R6 reload set");
    wr(12'h004, 32'h7);
    rd(12'h004, 32'h7, "R7 count");
    rd(12'h008, 32'h20, "R7 reload unchanged");

    // free-running: 3,2,1,0 on successive edges
    wr(12'h008, 32'h3);
    wr(12'h000, 32'h9);
    chk("R3 irq E0", irq, 0);
    @(negedge clk); chk("R3 irq E1", irq, 0);
    @(negedge clk); chk("R4 irq E2", irq, 0);
    @(negedge clk); chk("R4 irq at 1-to-0", irq, 1);
    wr(12'h000, 0);
    rd(12'h004, 32'h1, "R5 reload after zero then stop");
    idle(5);
    rd(12'h004, 32'h1, "R3 disabled hold");
    wr(12'h00C, 0);
    chk("R8 write 0 keeps", irq, 1);
    wr(12'h00C, 1);
    chk("R8 w1c clears", irq, 0);

    // external enable stepping
    wr(12'h008, 32'h2);
    wr(12'h000, 32'hB);
    idle(4);
    rd(12'h004, 32'h2, "R9 no step while low");
    pulse(); rd(12'h004, 32'h1, "R9 one step");
    pulse(); rd(12'h004, 32'h0, "R9 reach zero");
    chk("R4 irq ext", irq, 1);
    pulse(); rd(12'h004, 32'h2, "R5 one tick at zero then reload");
    wr(12'h00C, 1);

    // external clock: long high gives one tick
    wr(12'h000, 32'h5);
    wr(12'h004, 32'h5);
    @(negedge clk); ext_in = 1;
    idle(6);
    ext_in = 0;
    idle(3);
    rd(12'h004, 32'h4, "R10 one step per rise");
    pulse(); rd(12'h004, 32'h3, "R10 second rise");

    // interrupt enable off
    wr(12'h000, 0);
    wr(12'h008, 32'h1);
    wr(12'h000, 32'h1);
    idle(10);
    chk("R4 no irq when disabled", irq, 0);
    rd(12'h00C, 0, "R4 status clear");

    // zero reload
    wr(12'h000, 0);
    wr(12'h008, 0);
    wr(12'h000, 32'h9);
    idle(20);
    chk("R5 zero reload no irq", irq, 0);
    rd(12'h004, 0, "R5 zero reload parked");

    wait (act_q.size() == 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule